// File: doc/BRIEF.md
# Bit-Serial HDLC Frame Transmitter

This block turns bytes from a host into a bit-oriented framed serial stream. The host writes one byte at a time into a single holding register. At each character boundary the engine moves that byte into its shift register and sends it one bit per bit-rate enable pulse, least significant bit first. Whenever five ones in a row have gone out inside the payload or the check field, the engine inserts a zero. Between frames the line either rests at constant ones or repeats the flag character 0x7E, depending on a mode input. A frame opens with a flag, so the first byte of a frame is only taken once a flag has just gone out.

When the holding register is still empty at the end of a payload character, the engine reports an underrun and closes the frame. Two things decide how it closes: an underrun latch and an abort option. It either sends the inverted CRC-16 (polynomial x^16+x^12+x^5+1, preset to all ones) followed by a flag, or it sends eight ones followed by a flag, or it sends flags only. When the closing flag is loaded, the engine pulses the buffer-empty event once more. A byte written at that point starts the next frame, and the two frames share that one flag.

A fixed pipeline of bit-time stages sits between the shift register and the line. As a result, every character reaches the output exactly six bit-times after it is loaded.

Top module: `sdlc_tx`

## Requirements
- R1: After reset the line output is 1 on every bit-time, the holding register is empty, `wr_ready` is 1, no event pulses, and the underrun latch is set.
- R2: With `flag_idle`=1 and no frame in progress, the line repeats the flag, sent LSB first as 0,1,1,1,1,1,1,0. Exactly one such flag precedes the first payload bit of every frame.
- R3: A byte in the holding register is moved into the shift register only at the end of a flag. With `flag_idle`=0 outside a frame, a written byte stays held: `buf_full` remains 1, the line stays at 1, and no buffer-empty event fires.
- R4: `buf_empty_evt` pulses for one clock, the clock after the bit-rate step in which a byte moves to the shift register. `wr_ready` is 1 whenever the register is empty, and also in the clock where its byte is moved out, so a write in that clock is kept.
- R5: The first bit of a character appears on `txd` after exactly six bit-rate steps following the step that loaded it. `txd` changes only after a bit-rate step.
- R6: After five consecutive ones in payload or CRC bits a 0 is inserted, with the run carried across character boundaries. A 0xFF byte that follows a byte ending in 0 occupies 9 bit-times.
- R7: If the register is empty at the end of a payload character, `urun_evt` pulses in the clock after that step, and never together with `buf_empty_evt`. With the latch clear and `abort_on_urun`=0, the ones-complement of the CRC is sent LSB first with zero insertion, followed by a flag.
- R8: With the latch clear and `abort_on_urun`=1, the underrun sends eight ones without insertion, followed by a flag.
- R9: With the latch set, the underrun sends only a flag, and no buffer-empty event follows it.
- R10: After a CRC or abort closing, `buf_empty_evt` pulses in the step that loads the closing flag. A byte written then is loaded right after that single flag.
- R11: With `flag_idle`=0, the closing flag is sent once and the line then returns to constant 1.
- R12: Loading the closing flag sets the underrun latch. A pulse on `clr_urun_latch` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-rate step enable, one clock wide |
| flag_idle | input | 1 | 1: idle with repeated flags, 0: idle at constant ones |
| abort_on_urun | input | 1 | 1: close an underrun frame with an abort instead of the CRC |
| clr_urun_latch | input | 1 | Clears the underrun latch |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| wr_ready | output | 1 | A write in this clock is accepted |
| buf_full | output | 1 | Holding register occupied |
| txd | output | 1 | Serial line output |
| buf_empty_evt | output | 1 | Holding register emptied, or closing flag loaded |
| urun_evt | output | 1 | Underrun / end of message |

## Verification
A host write and the transfer of the held byte into the shift register can land in the same clock. The bench provokes this by holding a write strobe active while the register is still full and a frame is running, so the write is taken exactly at the transfer edge. It counts how often a write is accepted while `buf_full` reads 1. It then checks that every such byte appears in order in the decoded line stream, with the correct CRC, so that no byte is dropped or duplicated.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;

    localparam int CHAR_W = 8;
    localparam int FCS_W  = 16;
    localparam int CNT_W  = $clog2(FCS_W) + 1;
    localparam int RUN_W  = 3;

    localparam logic [RUN_W-1:0]  STUFF_RUN = RUN_W'(5);
    localparam logic [CHAR_W-1:0] FLAG_CHAR = 8'h7E;
    localparam logic [FCS_W-1:0]  FCS_INIT  = 16'hFFFF;
    localparam logic [FCS_W-1:0]  FCS_POLY  = 16'h8408;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_DATA,
        PH_CLOSE
    } phase_e;

    typedef struct packed {
        logic [FCS_W-1:0] sh;
        logic [CNT_W-1:0] cnt;
        phase_e           phase;
        logic             is_flag;
        logic             stuffed;
        logic [RUN_W-1:0] ones;
        logic             latch;
        logic             bemp;
        logic             urun;
    } eng_t;

    function automatic logic [FCS_W-1:0] fcs_step(input logic [FCS_W-1:0] c,
                                                  input logic [CHAR_W-1:0] b);
        logic [FCS_W-1:0] r;
        r = c;
        for (int i = 0; i < CHAR_W; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ FCS_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/sdlc_tx_hold.sv
module sdlc_tx_hold
    import sdlc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              take,
    output logic              ready,
    output logic              valid,
    output logic [CHAR_W-1:0] data
);
    typedef struct packed {
        logic              valid;
        logic [CHAR_W-1:0] data;
    } hold_t;

    hold_t q, d;

    assign ready = !q.valid || take;
    assign valid = q.valid;
    assign data  = q.data;

    always_comb begin
        d = q;
        if (wr_en && ready) begin
            d.valid = 1'b1;
            d.data  = wr_data;
        end else if (take) begin
            d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/sdlc_tx_fcs.sv
module sdlc_tx_fcs
    import sdlc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first,
    input  logic              more,
    input  logic [CHAR_W-1:0] data,
    output logic [FCS_W-1:0]  fcs
);
    logic [FCS_W-1:0] fcs_d, fcs_q;

    assign fcs = fcs_q;

    always_comb begin
        fcs_d = fcs_q;
        if (first)     fcs_d = fcs_step(FCS_INIT, data);
        else if (more) fcs_d = fcs_step(fcs_q, data);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fcs_q <= FCS_INIT;
        else        fcs_q <= fcs_d;
    end
endmodule

// File: rtl/sdlc_tx_delay.sv
module sdlc_tx_delay #(
    parameter int DEPTH = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] dly_d, dly_q;

    assign dout = dly_q[DEPTH-1];

    always_comb begin
        dly_d = dly_q;
        if (step) dly_d = {dly_q[DEPTH-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dly_q <= '1;
        else        dly_q <= dly_d;
    end
endmodule

// File: rtl/sdlc_tx.sv
module sdlc_tx
    import sdlc_tx_pkg::*;
#(
    parameter int LATENCY = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              flag_idle,
    input  logic              abort_on_urun,
    input  logic              clr_urun_latch,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              buf_full,
    output logic              txd,
    output logic              buf_empty_evt,
    output logic              urun_evt
);
    localparam logic [CNT_W-1:0] CHAR_BITS = CNT_W'(CHAR_W);
    localparam logic [CNT_W-1:0] FCS_BITS  = CNT_W'(FCS_W);

    eng_t q, d;

    logic              take, fcs_first, fcs_more, line_bit;
    logic              hold_valid;
    logic [CHAR_W-1:0] hold_data;
    logic [FCS_W-1:0]  fcs;

    sdlc_tx_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .ready   (wr_ready),
        .valid   (hold_valid),
        .data    (hold_data)
    );

    sdlc_tx_fcs u_fcs (
        .clk   (clk),
        .rst_n (rst_n),
        .first (fcs_first),
        .more  (fcs_more),
        .data  (hold_data),
        .fcs   (fcs)
    );

    sdlc_tx_delay #(.DEPTH(LATENCY)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (bit_en),
        .din   (line_bit),
        .dout  (txd)
    );

    assign buf_full      = hold_valid;
    assign buf_empty_evt = q.bemp;
    assign urun_evt      = q.urun;

    always_comb begin
        d         = q;
        d.bemp    = 1'b0;
        d.urun    = 1'b0;
        take      = 1'b0;
        fcs_first = 1'b0;
        fcs_more  = 1'b0;
        line_bit  = 1'b1;
        if (clr_urun_latch) d.latch = 1'b0;
        if (bit_en) begin
            if (q.ones == STUFF_RUN) begin
                // inserted zero; the current character waits one step
                line_bit = 1'b0;
                d.ones   = '0;
            end else begin
                line_bit = q.sh[0];
                d.sh     = {1'b1, q.sh[FCS_W-1:1]};
                d.cnt    = q.cnt - 1'b1;
                d.ones   = (q.stuffed && line_bit) ? q.ones + 1'b1 : '0;
                if (q.cnt == CNT_W'(1)) begin
                    // character boundary: choose what goes next
                    d.cnt     = CHAR_BITS;
                    d.stuffed = 1'b0;
                    d.is_flag = 1'b0;
                    d.sh      = '1;
                    unique case (q.phase)
                        PH_IDLE: begin
                            if (q.is_flag && hold_valid) begin
                                d.sh      = {{(FCS_W-CHAR_W){1'b1}}, hold_data};
                                d.stuffed = 1'b1;
                                d.phase   = PH_DATA;
                                d.bemp    = 1'b1;
                                take      = 1'b1;
                                fcs_first = 1'b1;
                            end else if (flag_idle) begin
                                d.sh      = {{(FCS_W-CHAR_W){1'b1}}, FLAG_CHAR};
                                d.is_flag = 1'b1;
                            end
                        end
                        PH_DATA: begin
                            if (hold_valid) begin
                                d.sh      = {{(FCS_W-CHAR_W){1'b1}}, hold_data};
                                d.stuffed = 1'b1;
                                d.bemp    = 1'b1;
                                take      = 1'b1;
                                fcs_more  = 1'b1;
                            end else begin
                                d.urun = 1'b1;
                                if (q.latch) begin
                                    d.sh      = {{(FCS_W-CHAR_W){1'b1}}, FLAG_CHAR};
                                    d.is_flag = 1'b1;
                                    d.phase   = PH_IDLE;
                                end else if (abort_on_urun) begin
                                    d.phase = PH_CLOSE;
                                end else begin
                                    d.sh      = ~fcs;
                                    d.cnt     = FCS_BITS;
                                    d.stuffed = 1'b1;
                                    d.phase   = PH_CLOSE;
                                end
                            end
                        end
                        default: begin
                            d.sh      = {{(FCS_W-CHAR_W){1'b1}}, FLAG_CHAR};
                            d.is_flag = 1'b1;
                            d.phase   = PH_IDLE;
                            d.latch   = 1'b1;
                            d.bemp    = 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= '0;
            q.sh      <= '1;
            q.cnt     <= CHAR_BITS;
            q.phase   <= PH_IDLE;
            q.latch   <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/sdlc_tx_chk.sv
module sdlc_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic wr_en,
    input logic wr_ready,
    input logic buf_full,
    input logic txd,
    input logic buf_empty_evt,
    input logic urun_evt
);
    AST_BEMP_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty_evt |-> $past(bit_en)); // R4

    AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_full |-> wr_ready); // R4

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ready) |=> buf_full); // R3

    AST_LINE_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_en) |-> $stable(txd)); // R5

    AST_URUN_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        urun_evt |-> $past(!buf_full)); // R7

    AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(urun_evt && buf_empty_evt)); // R7
endmodule

bind sdlc_tx sdlc_tx_chk u_chk (.*);

// File: tb/sdlc_tx_bench.sv
`timescale 1ns/100ps
module sdlc_tx_bench;
    logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0;
    logic flag_idle = 1'b0, abort_on_urun = 1'b0, clr_urun_latch = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic wr_ready, buf_full, txd, buf_empty_evt, urun_evt;

    sdlc_tx u_sdlc_tx (.*);

    always #2.5 clk = ~clk;

    int n_total = 0, n_fail = 0, n_coinc = 0;
    int nbits = 0, last_bemp = -1, last_urun = -1;
    logic stream [0:8191];
    logic bemp_at [0:8191];
    logic urun_at [0:8191];
    logic be_seen = 1'b0;
    int div = 0;

    always @(negedge clk) begin
        div = (div + 1) % 4;
        bit_en = rst_n && (div == 0);
    end
    always @(posedge clk) be_seen <= bit_en;
    always @(negedge clk) begin
        if (rst_n && be_seen && nbits < 8192) begin
            stream[nbits]  = txd;
            bemp_at[nbits] = buf_empty_evt;
            urun_at[nbits] = urun_evt;
            if (buf_empty_evt) last_bemp = nbits;
            if (urun_evt) last_urun = nbits;
            nbits++;
        end
    end

    logic [7:0] fb [0:3][0:3];
    int fn [0:3], ftk [0:3], fst [0:3], ffinal [0:3], fpend [0:3], fk0 [0:3];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int find_bemp(input int from);
        for (int i = from; i < nbits; i++) if (bemp_at[i]) return i;
        return -1;
    endfunction

    function automatic int find_urun(input int from);
        for (int i = from; i < nbits; i++) if (urun_at[i]) return i;
        return -1;
    endfunction

    task automatic step_wait();
        @(negedge clk); #0.5;
    endtask

    task automatic wait_bits(input int n);
        int target = nbits + n;
        while (nbits < target) step_wait();
    endtask

    task automatic write_byte(input logic [7:0] b);
        logic r = 1'b0;
        @(negedge clk); wr_en = 1'b1; wr_data = b;
        while (!r) begin
            #0.5;
            r = wr_ready;
            if (r && buf_full) n_coinc++;
            if (!r) @(negedge clk);
        end
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic run_frame(input int s, input bit skip_first, input bit clr,
                             input bit mark_after);
        if (!skip_first) fst[s] = nbits;
        if (clr) begin
            @(negedge clk); clr_urun_latch = 1'b1;
            @(negedge clk); clr_urun_latch = 1'b0;
        end
        for (int i = (skip_first ? 1 : 0); i < fn[s]; i++) begin
            write_byte(fb[s][i]);
            if (mark_after && i == 0) begin
                while (last_bemp < fst[s]) step_wait();
                flag_idle = 1'b0;
            end
        end
        while (last_urun < fst[s]) step_wait();
        if (ftk[s] < 2) begin
            while (last_bemp <= last_urun) step_wait();
            ffinal[s] = last_bemp;
        end else begin
            wait_bits(30);
        end
    endtask

    task automatic check_frame(input int s);
        logic e [0:255];
        int n = 0, ones = 0, lend = 0, ld, lt = 0, k0, u, bad = -1, fl;
        logic [15:0] crc = 16'hFFFF;
        logic [15:0] fcs;
        string tg;
        tg = (ftk[s] == 0) ? "R7" : (ftk[s] == 1) ? "R8" : "R9";
        k0 = find_bemp(fst[s]);
        fk0[s] = k0;
        for (int i = 0; i < fn[s]; i++)
            for (int b = 0; b < 8; b++) begin
                logic v = fb[s][i][b];
                crc = (crc[0] ^ v) ? ((crc >> 1) ^ 16'h8408) : (crc >> 1);
                e[n] = v; n++; ones = v ? ones + 1 : 0; lend = n;
                if (ones == 5) begin e[n] = 1'b0; n++; ones = 0; end
            end
        ld = lend;
        fpend[s] = 0;
        if (ftk[s] == 0) begin
            fcs = ~crc;
            for (int b = 0; b < 16; b++) begin
                e[n] = fcs[b]; n++; ones = fcs[b] ? ones + 1 : 0; lend = n;
                if (ones == 5) begin e[n] = 1'b0; n++; ones = 0; end
            end
            lt = lend;
            fpend[s] = (n != lend) ? 1 : 0;
        end else if (ftk[s] == 1) begin
            for (int b = 0; b < 8; b++) begin e[n] = 1'b1; n++; end
            lt = n;
        end
        fl = n;
        for (int b = 0; b < 8; b++) begin e[n] = (b != 0 && b != 7); n++; end
        // R5 R6: payload starts six steps after its load; stuffing and closing
        for (int i = 0; i < n; i++)
            if (bad < 0 && stream[k0 + 6 + i] !== e[i]) bad = i;
        chk(k0 >= 0 && bad < 0, {tg, " R5 R6"}, "line stream mismatch at bit", bad, -1);
        // R2: one flag right before the first payload bit
        bad = -1;
        for (int b = 0; b < 8; b++)
            if (bad < 0 && stream[k0 - 2 + b] !== logic'(b != 0 && b != 7)) bad = b;
        chk(bad < 0, "R2", "opening flag bit", bad, -1);
        u = find_urun(fst[s]);
        chk(u == k0 + ld, "R7", "underrun step", u, k0 + ld);
        if (ftk[s] < 2)
            chk(find_bemp(u + 1) == k0 + lt, "R10", "closing flag event step",
                find_bemp(u + 1), k0 + lt);
        else
            chk(find_bemp(u + 1) < 0 || find_bemp(u + 1) > u + 20, "R9",
                "event after flags-only close", find_bemp(u + 1), -1);
        if (s == 3) begin
            bad = -1;
            for (int i = 0; i < 16; i++)
                if (bad < 0 && stream[k0 + 6 + fl + 8 + i] !== 1'b1) bad = i;
            chk(bad < 0, "R11", "line not back at ones, bit", bad, -1);
        end
    endtask

    task automatic t_reset();
        int bad = -1;
        wait_bits(20);
        for (int i = 0; i < 20; i++) if (bad < 0 && stream[i] !== 1'b1) bad = i;
        chk(bad < 0, "R1", "mark idle bit", bad, -1);
        chk(buf_full == 1'b0 && wr_ready == 1'b1, "R1", "holding register state",
            buf_full, 0);
        chk(last_bemp < 0 && last_urun < 0, "R1", "event after reset", last_bemp, -1);
    endtask

    task automatic t_mark_hold();
        int st, bad = -1;
        write_byte(8'h81);
        st = nbits;
        wait_bits(30);
        for (int i = st; i < nbits; i++) if (bad < 0 && stream[i] !== 1'b1) bad = i;
        chk(bad < 0, "R3", "line in mark idle with byte held", bad, -1);
        chk(buf_full == 1'b1, "R3", "byte still held", buf_full, 1);
        chk(find_bemp(st) < 0, "R3", "premature buffer-empty event", find_bemp(st), -1);
    endtask

    task automatic t_frames();
        int b2, b3, b4;
        fb[0][0] = 8'h81; fb[0][1] = 8'h42; fb[0][2] = 8'hFF; fb[0][3] = 8'h42;
        fn[0] = 4; ftk[0] = 0;
        fb[1][0] = 8'hA5; fb[1][1] = 8'h00; fn[1] = 2; ftk[1] = 1;
        fb[2][0] = 8'h3C; fn[2] = 1; ftk[2] = 2;
        fb[3][0] = 8'h12; fb[3][1] = 8'h34; fn[3] = 2; ftk[3] = 0;
        // frame 0: the held 0x81 opens it once flags start; latch cleared (R12)
        fst[0] = nbits;
        @(negedge clk); clr_urun_latch = 1'b1;
        @(negedge clk); clr_urun_latch = 1'b0;
        flag_idle = 1'b1;
        run_frame(0, 1'b1, 1'b0, 1'b0);
        // frame 1 back to back with abort closing
        abort_on_urun = 1'b1;
        run_frame(1, 1'b0, 1'b1, 1'b0);
        abort_on_urun = 1'b0;
        // frame 2: latch left set by frame 1 closing (R12) -> flags only
        run_frame(2, 1'b0, 1'b0, 1'b0);
        // frame 3: latch cleared again, mark idle after first byte
        run_frame(3, 1'b0, 1'b1, 1'b1);
        wait_bits(60);
        for (int s = 0; s < 4; s++) check_frame(s);
        b2 = find_bemp(fk0[0] + 1);
        b3 = find_bemp(b2 + 1);
        b4 = find_bemp(b3 + 1);
        chk(b4 - b3 == 9, "R6", "bit-times of 0xFF", b4 - b3, 9);
        chk(fk0[1] == ffinal[0] + 8 + fpend[0], "R10", "shared flag, next load step",
            fk0[1], ffinal[0] + 8 + fpend[0]);
        chk(find_urun(fst[2]) >= 0, "R12", "latched frame underrun seen",
            find_urun(fst[2]), 0);
        chk(n_coinc > 0, "R4", "writes accepted in a transfer clock", n_coinc, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mark_hold();
        t_frames();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule